// File: doc/BRIEF.md
# Communication Watchdog Mode Controller

This block watches a serial control bus for completed, valid transactions and decides who controls the channels of a two-channel LED driver. While transactions keep arriving, the channels follow the enable and dimming values that the bus has written. A watchdog counter restarts on every transaction pulse. When it reaches its limit, the block falls back to one of two safe modes. A silent bus while the chip is still starting up selects standalone mode. In that mode the bus is shut off and each channel follows its external dimming pin, gated by the limp-home pin. A silent bus after start-up has finished selects limp-home mode. In that mode each channel takes its settings from a small shadow register set. Software loads those registers while the chip is still starting up.

Both fallback modes are sticky, and only the active-low reset leaves them. The watchdog can be switched off. While it is off, the block never falls back, whatever happens on the bus. The mode appears on a 2-bit output, and each channel also reports which source drives it.

Top module: `comm_wdog_mode_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, mode is 00 (start-up), spi_block, fail_boot, fail_run and every ch_en bit are 0, ch_dim is 0, and every ch_src code is 00.
- R2: While wd_en is 0, mode never becomes 10 or 11, whatever the bus activity.
- R3: In start-up, boot_done sampled high at a clock edge moves mode to 01 (normal) at that edge, unless the watchdog expires at the same edge.
- R4: With wd_en high in start-up or normal, the watchdog expires at the TIMEOUT-th consecutive clock edge without txn_done. A txn_done pulse at any edge, including that TIMEOUT-th edge, restarts the count and prevents expiry.
- R5: Expiry in start-up sets mode to 10 (standalone) at the expiring edge and sets fail_boot and spi_block.
- R6: Expiry in normal sets mode to 11 (limp-home) at the expiring edge, sets fail_run, and leaves spi_block at 0.
- R7: Modes 10 and 11 and their flags hold until reset, whatever txn_done, boot_done or wd_en do.
- R8: In standalone, ch_en[i] = ext_dim[i] AND lh_pin, the channel's dim field is all ones, and ch_src code is 01.
- R9: In limp-home, ch_en[i] and channel i's dim field come from limp-home register i, and ch_src code is 10.
- R10: In normal, ch_en and ch_dim pass bus_en and bus_dim through with ch_src code 00. In start-up, ch_en and ch_dim are 0 with code 00.
- R11: A write to limp-home register i (lh_wr_sel[i] high at an edge, loading lh_wr_on and lh_wr_dim) takes effect only while mode is 00. It is ignored in every other mode.
- R12: When boot_done and watchdog expiry fall on the same edge in start-up, expiry wins and mode becomes 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the block to start-up |
| wd_en | input | 1 | Watchdog enable |
| txn_done | input | 1 | One-cycle pulse per completed valid bus transaction |
| boot_done | input | 1 | Start-up sequence complete |
| lh_wr_sel | input | NUM_CH | Per-channel write strobe for the limp-home registers |
| lh_wr_on | input | 1 | Enable value written to the selected limp-home registers |
| lh_wr_dim | input | DIM_W | Dimming value written to the selected limp-home registers |
| bus_en | input | NUM_CH | Channel enables written over the bus |
| bus_dim | input | NUM_CH*DIM_W | Dimming codes written over the bus, channel 0 in the low field |
| ext_dim | input | NUM_CH | External per-channel dimming pins |
| lh_pin | input | 1 | Limp-home input pin |
| mode | output | 2 | 00 start-up, 01 normal, 10 standalone, 11 limp-home |
| spi_block | output | 1 | High while bus access is disabled |
| fail_boot | output | 1 | Sticky: watchdog expired during start-up |
| fail_run | output | 1 | Sticky: watchdog expired during normal operation |
| ch_en | output | NUM_CH | Per-channel enable |
| ch_dim | output | NUM_CH*DIM_W | Per-channel dimming code |
| ch_src | output | 2*NUM_CH | Per-channel source: 00 bus, 01 pins, 10 limp-home registers |

## Verification
Two pairs of events can land on the same edge. The first is a transaction pulse on the edge where the count reaches its limit. The bench holds the bus idle for exactly TIMEOUT-1 edges and then pulses txn_done, and the mode must stay normal. The second is boot_done on the expiring edge in start-up. There the mode must become standalone, not normal. A behavioural model in the bench predicts mode, flags and every channel output on every clock, and the mismatch count judges both collisions.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

   typedef enum logic [1:0] {
      MD_BOOT = 2'b00,
      MD_RUN  = 2'b01,
      MD_SOLO = 2'b10,
      MD_LIMP = 2'b11
   } wdm_mode_e;

   typedef enum logic [1:0] {
      SRC_BUS  = 2'b00,
      SRC_PIN  = 2'b01,
      SRC_LIMP = 2'b10
   } wdm_src_e;

   function automatic logic is_fallback(input wdm_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/wdm_timer.sv
module wdm_timer #(
   parameter int TIMEOUT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic kick,
   output logic expire
);
   localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
   localparam bit POW2 = ((TIMEOUT & (TIMEOUT - 1)) == 0);

   logic [CW-1:0] cnt_q;
   logic          at_last;

   generate
      if (POW2) begin : g_wrap
         assign at_last = &cnt_q;
      end else begin : g_cmp
         assign at_last = (cnt_q == LAST);
      end
   endgenerate

   assign expire = run & ~kick & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (!run || kick || expire) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdm_fsm.sv
module wdm_fsm
   import wdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      expire,
   input  logic      boot_done,
   output wdm_mode_e mode_q,
   output logic      fail_boot_q,
   output logic      fail_run_q
);
   wdm_mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MD_BOOT: begin
            if (expire)         mode_d = MD_SOLO;
            else if (boot_done) mode_d = MD_RUN;
         end
         MD_RUN:  if (expire) mode_d = MD_LIMP;
         default: mode_d = mode_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= MD_BOOT;
         fail_boot_q <= 1'b0;
         fail_run_q  <= 1'b0;
      end else begin
         mode_q      <= mode_d;
         fail_boot_q <= fail_boot_q | (mode_q == MD_BOOT && expire);
         fail_run_q  <= fail_run_q  | (mode_q == MD_RUN  && expire);
      end
   end
endmodule

// File: rtl/wdm_limp_regs.sv
module wdm_limp_regs #(
   parameter int NUM_CH = 2,
   parameter int DIM_W  = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_open,
   input  logic [NUM_CH-1:0]       wr_sel,
   input  logic                    wr_on,
   input  logic [DIM_W-1:0]        wr_dim,
   output logic [NUM_CH-1:0]       limp_en,
   output logic [NUM_CH*DIM_W-1:0] limp_dim
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic             on_q;
         logic [DIM_W-1:0] dim_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               on_q  <= 1'b0;
               dim_q <= '0;
            end else if (wr_open && wr_sel[i]) begin
               on_q  <= wr_on;
               dim_q <= wr_dim;
            end
         end
         assign limp_en[i] = on_q;
         assign limp_dim[i*DIM_W +: DIM_W] = dim_q;
      end
   endgenerate
endmodule

// File: rtl/wdm_out_mux.sv
module wdm_out_mux
   import wdm_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DIM_W  = 10
) (
   input  wdm_mode_e               mode,
   input  logic [NUM_CH-1:0]       bus_en,
   input  logic [NUM_CH*DIM_W-1:0] bus_dim,
   input  logic [NUM_CH-1:0]       ext_dim,
   input  logic                    lh_pin,
   input  logic [NUM_CH-1:0]       limp_en,
   input  logic [NUM_CH*DIM_W-1:0] limp_dim,
   output logic [NUM_CH-1:0]       ch_en,
   output logic [NUM_CH*DIM_W-1:0] ch_dim,
   output logic [2*NUM_CH-1:0]     ch_src
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         always_comb begin
            unique case (mode)
               MD_RUN: begin
                  ch_en[i]                = bus_en[i];
                  ch_dim[i*DIM_W +: DIM_W] = bus_dim[i*DIM_W +: DIM_W];
                  ch_src[2*i +: 2]        = SRC_BUS;
               end
               MD_SOLO: begin
                  ch_en[i]                = ext_dim[i] & lh_pin;
                  ch_dim[i*DIM_W +: DIM_W] = '1;
                  ch_src[2*i +: 2]        = SRC_PIN;
               end
               MD_LIMP: begin
                  ch_en[i]                = limp_en[i];
                  ch_dim[i*DIM_W +: DIM_W] = limp_dim[i*DIM_W +: DIM_W];
                  ch_src[2*i +: 2]        = SRC_LIMP;
               end
               default: begin
                  ch_en[i]                = 1'b0;
                  ch_dim[i*DIM_W +: DIM_W] = '0;
                  ch_src[2*i +: 2]        = SRC_BUS;
               end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/comm_wdog_mode_ctrl.sv
module comm_wdog_mode_ctrl
   import wdm_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int DIM_W   = 10,
   parameter int TIMEOUT = 1024
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wd_en,
   input  logic                    txn_done,
   input  logic                    boot_done,
   input  logic [NUM_CH-1:0]       lh_wr_sel,
   input  logic                    lh_wr_on,
   input  logic [DIM_W-1:0]        lh_wr_dim,
   input  logic [NUM_CH-1:0]       bus_en,
   input  logic [NUM_CH*DIM_W-1:0] bus_dim,
   input  logic [NUM_CH-1:0]       ext_dim,
   input  logic                    lh_pin,
   output logic [1:0]              mode,
   output logic                    spi_block,
   output logic                    fail_boot,
   output logic                    fail_run,
   output logic [NUM_CH-1:0]       ch_en,
   output logic [NUM_CH*DIM_W-1:0] ch_dim,
   output logic [2*NUM_CH-1:0]     ch_src
);
   generate
      if (NUM_CH < 1)   begin : g_bad_ch  $error("NUM_CH must be at least 1"); end
      if (DIM_W < 1)    begin : g_bad_dim $error("DIM_W must be at least 1"); end
      if (TIMEOUT < 2)  begin : g_bad_to  $error("TIMEOUT must be at least 2"); end
   endgenerate

   wdm_mode_e             mode_q;
   logic                  expire;
   logic                  supervise;
   logic [NUM_CH-1:0]     limp_en;
   logic [NUM_CH*DIM_W-1:0] limp_dim;

   assign supervise = wd_en & ~is_fallback(mode_q);

   wdm_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (supervise),
      .kick   (txn_done),
      .expire (expire)
   );

   wdm_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .expire      (expire),
      .boot_done   (boot_done),
      .mode_q      (mode_q),
      .fail_boot_q (fail_boot),
      .fail_run_q  (fail_run)
   );

   wdm_limp_regs #(.NUM_CH(NUM_CH), .DIM_W(DIM_W)) u_limp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_open  (mode_q == MD_BOOT),
      .wr_sel   (lh_wr_sel),
      .wr_on    (lh_wr_on),
      .wr_dim   (lh_wr_dim),
      .limp_en  (limp_en),
      .limp_dim (limp_dim)
   );

   wdm_out_mux #(.NUM_CH(NUM_CH), .DIM_W(DIM_W)) u_mux (
      .mode     (mode_q),
      .bus_en   (bus_en),
      .bus_dim  (bus_dim),
      .ext_dim  (ext_dim),
      .lh_pin   (lh_pin),
      .limp_en  (limp_en),
      .limp_dim (limp_dim),
      .ch_en    (ch_en),
      .ch_dim   (ch_dim),
      .ch_src   (ch_src)
   );

   assign mode      = mode_q;
   assign spi_block = (mode_q == MD_SOLO);
endmodule

// File: rtl/wdm_checker.sv
module wdm_checker #(
   parameter int NUM_CH  = 2,
   parameter int DIM_W   = 10,
   parameter int TIMEOUT = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wd_en,
   input logic              txn_done,
   input logic              boot_done,
   input logic [NUM_CH-1:0] ext_dim,
   input logic              lh_pin,
   input logic [1:0]        mode,
   input logic              spi_block,
   input logic              fail_boot,
   input logic              fail_run,
   input logic [NUM_CH-1:0] ch_en
);
   int unsigned idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idle <= 0;
      else if (!wd_en || mode[1] || txn_done) idle <= 0;
      else idle <= idle + 1;
   end

   a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_en && !mode[1]) |=> !mode[1]);

   a_r3_no_return_to_boot: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=> (mode == 2'b01 || mode == 2'b11));

   a_r4_kick_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_done && !mode[1]) |=> !mode[1]);

   a_r4_expiry_on_time: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_en && !mode[1] && !txn_done && idle == TIMEOUT - 1) |=> mode[1]);

   a_r5_block_only_from_boot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_block) |-> ($past(mode) == 2'b00 && fail_boot));

   a_r6_limp_only_from_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_run) |-> ($past(mode) == 2'b01 && mode == 2'b11 && !spi_block));

   a_r7_solo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |=> (mode == 2'b10 && fail_boot));

   a_r7_limp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |=> (mode == 2'b11 && fail_run));

   a_r8_pin_control: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> (ch_en == (ext_dim & {NUM_CH{lh_pin}})));

   a_r12_expiry_beats_boot: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && boot_done && wd_en && !txn_done && idle == TIMEOUT - 1)
      |=> (mode == 2'b10));
endmodule

bind comm_wdog_mode_ctrl wdm_checker #(
   .NUM_CH(NUM_CH), .DIM_W(DIM_W), .TIMEOUT(TIMEOUT)
) u_chk (.*);

// File: tb/sim_comm_wdog_mode_ctrl.sv
module sim_comm_wdog_mode_ctrl;
   localparam int NUM_CH = 2;
   localparam int DIM_W  = 10;
   localparam int TO     = 32;

   logic clk = 1'b0, rst_n = 1'b0, wd_en = 1'b0, txn = 1'b0, boot = 1'b0;
   logic [NUM_CH-1:0]       lh_we = '0;
   logic                    lh_on = 1'b0;
   logic [DIM_W-1:0]        lh_d  = '0;
   logic [NUM_CH-1:0]       bus_en = '0;
   logic [NUM_CH*DIM_W-1:0] bus_dim = '0;
   logic [NUM_CH-1:0]       ext = '0;
   logic                    lhp = 1'b0;
   logic [1:0]              mode;
   logic                    spi_block, fail_boot, fail_run;
   logic [NUM_CH-1:0]       ch_en;
   logic [NUM_CH*DIM_W-1:0] ch_dim;
   logic [2*NUM_CH-1:0]     ch_src;

   int vectors = 0, fails = 0;

   int  m_mode = 0, m_idle = 0;
   bit  m_fb = 0, m_fr = 0;
   bit  m_on [NUM_CH];
   logic [DIM_W-1:0] m_dim [NUM_CH];

   always #4 clk = ~clk;

   comm_wdog_mode_ctrl #(.NUM_CH(NUM_CH), .DIM_W(DIM_W), .TIMEOUT(TO)) u0 (
      .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .txn_done(txn), .boot_done(boot),
      .lh_wr_sel(lh_we), .lh_wr_on(lh_on), .lh_wr_dim(lh_d),
      .bus_en(bus_en), .bus_dim(bus_dim), .ext_dim(ext), .lh_pin(lhp),
      .mode(mode), .spi_block(spi_block), .fail_boot(fail_boot), .fail_run(fail_run),
      .ch_en(ch_en), .ch_dim(ch_dim), .ch_src(ch_src));

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit expire;
      if (!rst_n) begin
         m_mode = 0; m_idle = 0; m_fb = 0; m_fr = 0;
         for (int i = 0; i < NUM_CH; i++) begin m_on[i] = 0; m_dim[i] = '0; end
         return;
      end
      expire = wd_en && m_mode < 2 && m_idle == TO - 1 && !txn;
      if (m_mode == 0)
         for (int i = 0; i < NUM_CH; i++)
            if (lh_we[i]) begin m_on[i] = lh_on; m_dim[i] = lh_d; end
      if (!wd_en || m_mode >= 2 || txn || expire) m_idle = 0;
      else m_idle++;
      if (m_mode == 0) begin
         if (expire) begin m_mode = 2; m_fb = 1; end
         else if (boot) m_mode = 1;
      end else if (m_mode == 1 && expire) begin
         m_mode = 3; m_fr = 1;
      end
   endtask

   task automatic compare_all();
      string tg;
      logic [NUM_CH-1:0]       e_en;
      logic [NUM_CH*DIM_W-1:0] e_dim;
      logic [2*NUM_CH-1:0]     e_src;
      tg = (m_mode == 2) ? "R8" : (m_mode == 3) ? "R9" : "R10";
      for (int i = 0; i < NUM_CH; i++) begin
         case (m_mode)
            1: begin e_en[i] = bus_en[i]; e_dim[i*DIM_W +: DIM_W] = bus_dim[i*DIM_W +: DIM_W]; e_src[2*i +: 2] = 2'b00; end
            2: begin e_en[i] = ext[i] & lhp; e_dim[i*DIM_W +: DIM_W] = '1; e_src[2*i +: 2] = 2'b01; end
            3: begin e_en[i] = m_on[i]; e_dim[i*DIM_W +: DIM_W] = m_dim[i]; e_src[2*i +: 2] = 2'b10; end
            default: begin e_en[i] = 1'b0; e_dim[i*DIM_W +: DIM_W] = '0; e_src[2*i +: 2] = 2'b00; end
         endcase
      end
      chk("R4", "mode", 64'(mode), 64'(m_mode));
      chk("R5", "spi_block/fail_boot", {spi_block, fail_boot}, {m_mode == 2, m_fb});
      chk("R6", "fail_run", 64'(fail_run), 64'(m_fr));
      chk(tg, "ch_en", 64'(ch_en), 64'(e_en));
      chk(tg, "ch_dim", 64'(ch_dim), 64'(e_dim));
      chk(tg, "ch_src", 64'(ch_src), 64'(e_src));
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      model_step();
      compare_all();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired before the scenario completed");
      finish_run();
   end

   initial begin
      repeat (3) step();
      chk("R1", "reset mode", 64'(mode), 64'd0);
      chk("R1", "reset outputs", {spi_block, fail_boot, fail_run, ch_en, ch_src}, 64'd0);
      chk("R1", "reset dim", 64'(ch_dim), 64'd0);
      rst_n = 1'b1;

      // watchdog off: long silence in start-up
      repeat (100) step();
      chk("R2", "mode after silence, wd off", 64'(mode), 64'd0);

      // load limp-home registers during start-up
      lh_we = 2'b01; lh_on = 1'b1; lh_d = 10'h155; step();
      lh_we = 2'b10; lh_on = 1'b0; lh_d = 10'h2AA; step();
      lh_we = '0;
      boot = 1'b1; step(); boot = 1'b0;
      chk("R3", "mode after boot_done", 64'(mode), 64'd1);

      bus_en = 2'b11;
      bus_dim = 20'($urandom);
      repeat (100) step();
      chk("R2", "normal mode, wd off", 64'(mode), 64'd1);

      // watchdog on with regular kicks
      wd_en = 1'b1;
      for (int k = 0; k < 6; k++) begin
         repeat (20) step();
         txn = 1'b1; bus_en = 2'($urandom); bus_dim = 20'($urandom); step(); txn = 1'b0;
      end
      repeat (TO - 1) step();
      txn = 1'b1; step(); txn = 1'b0;
      chk("R4", "kick on the terminal edge", 64'(mode), 64'd1);

      // write attempt outside start-up must be ignored
      lh_we = 2'b11; lh_on = 1'b1; lh_d = 10'h3FF; step(); lh_we = '0;

      txn = 1'b1; step(); txn = 1'b0;
      repeat (TO - 1) step();
      chk("R6", "one edge before expiry", 64'(mode), 64'd1);
      step();
      chk("R6", "limp-home entered", 64'(mode), 64'd3);
      chk("R6", "spi_block in limp-home", 64'(spi_block), 64'd0);
      chk("R11", "limp-home dim kept start-up values", 64'(ch_dim), 64'({10'h2AA, 10'h155}));
      chk("R9", "limp-home enables", 64'(ch_en), 64'd1);

      txn = 1'b1; boot = 1'b1; repeat (5) step(); txn = 1'b0; boot = 1'b0;
      wd_en = 1'b0; repeat (3) step(); wd_en = 1'b1;
      chk("R7", "limp-home sticky", 64'(mode), 64'd3);

      // standalone path
      rst_n = 1'b0; step(); rst_n = 1'b1;
      lh_we = 2'b11; lh_on = 1'b1; lh_d = 10'h0F0; step(); lh_we = '0;
      repeat (TO - 2) step();
      chk("R5", "one edge before expiry", 64'(mode), 64'd0);
      step();
      chk("R5", "standalone entered", 64'(mode), 64'd2);
      chk("R5", "spi_block set", 64'(spi_block), 64'd1);
      for (int p = 0; p < 8; p++) begin
         ext = 2'(p); lhp = p[2]; step();
         chk("R8", "pin-driven enable", 64'(ch_en), 64'(2'(p) & {2{p[2]}}));
      end
      txn = 1'b1; boot = 1'b1; repeat (4) step(); txn = 1'b0; boot = 1'b0;
      chk("R7", "standalone sticky", 64'(mode), 64'd2);

      // boot_done on the expiring edge
      rst_n = 1'b0; step(); rst_n = 1'b1;
      repeat (TO - 1) step();
      boot = 1'b1; step(); boot = 1'b0;
      chk("R12", "expiry beats boot_done", 64'(mode), 64'd2);
      repeat (4) step();

      finish_run();
   end
endmodule